// File: doc/BRIEF.md
# Arbitrated Two-Host Control Register File

This block holds the configuration registers of a digital receive channel: operating mode, oscillator tuning and phase, stage gain shifts, decimation factors and filter-control words. Two hosts can reach every register. One is a byte-wide parallel port with a ready handshake. The other is a serial control port whose shifting logic sits elsewhere and presents full 32-bit words through a request, address and data interface. Both ports may run at the same time. A small arbiter sequences them so that only one access touches the storage at once.

When both ports ask in the same cycle, the serial side is served first. A parallel access that has already been granted always runs to completion before any serial access starts. While a parallel request waits, its ready output stays low, and the request is served as soon as the serial access ends. Each granted access occupies the storage for two clocks.

The sync-mask location is double-buffered. A write lands in a shadow copy, a read returns the active mask, and a single-cycle load pulse copies the shadow into the active mask. Stored values leave the block on a flat configuration bus for the datapath.

Top module: `ctrl_regfile_arb`

## Requirements
- R1: Every register is reachable from both ports, and a value written through one port reads back through the other. The parallel port selects a byte lane of the 32-bit word with `pp_byte` (0 selects bits 7:0, 3 selects bits 31:24).
- R2: When both ports are requesting and the arbiter is idle, the serial access is granted first. A parallel access that has already been granted completes before a serial request that arrives later is granted.
- R3: A parallel request that loses arbitration keeps `pp_ready` low until the serial access has finished, and is then performed.
- R4: Bit 0 of the mode register (address 0x300) is the soft-reset bit. It is 1 after hardware reset and stays 1 until a write clears it. Its value is driven on `soft_reset`.
- R5: Bit 3 of the mode register is the sync-master bit and is 0 after hardware reset, as is every register other than bit 0 of the mode register. Its value is driven on `sync_master`.
- R6: A write to address 0x302 updates only the shadow mask. A read of 0x302 returns the active mask. A one-cycle `sync_load` pulse copies the shadow into the active mask.
- R7: Implemented bits per address are as follows. 0x300 has bits 3:0. 0x301 has bits 2:0. 0x302 and 0x303 have 32 bits. 0x304 has bits 15:0. 0x305 has mask 0xF7. 0x307 has bits 4:0. 0x309 has bits 2:0. 0x306, 0x308, 0x30A, 0x30B and 0x30C have bits 7:0. 0x30D has no bits. All other bits read 0 and ignore writes.
- R8: Addresses below 0x300 and above 0x30D read as 0, and writes to them change no register.
- R9: A granted access takes two clocks. With the arbiter idle, a request raised before clock edge n is granted at edge n and completes at edge n+2. After edge n+2, `pp_ready` returns high with `pp_rdata` valid, or `sp_done` pulses high for one cycle with `sp_rdata` valid.
- R10: A serial write replaces all 32 bits. A parallel write changes only the selected byte lane and leaves the other bytes of that register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| pp_req | input | 1 | Parallel request, held until `pp_ready` returns high |
| pp_wr | input | 1 | Parallel write (1) or read (0) |
| pp_addr | input | 10 | Parallel register address |
| pp_byte | input | 2 | Parallel byte-lane select |
| pp_wdata | input | 8 | Parallel write byte |
| pp_rdata | output | 8 | Parallel read byte |
| pp_ready | output | 1 | Parallel ready: low while a request is pending |
| sp_req | input | 1 | Serial request, held until `sp_done` |
| sp_wr | input | 1 | Serial write (1) or read (0) |
| sp_addr | input | 10 | Serial register address |
| sp_wdata | input | 32 | Serial write word |
| sp_rdata | output | 32 | Serial read word |
| sp_done | output | 1 | One-cycle serial completion pulse |
| sync_load | input | 1 | Copies the shadow mask into the active mask |
| soft_reset | output | 1 | Soft-reset bit of the mode register |
| sync_master | output | 1 | Sync-master bit of the mode register |
| cfg_flat | output | 448 | All registers, 32 bits each, index 0 in the low word, active mask in word 2 |

## Verification
The hardest situations to reach are the two arbitration orderings. In one, both hosts raise requests on the same clock. In the other, a serial request arrives while a parallel access is already in flight. The bench reaches both by running the parallel and serial drivers in parallel threads, started in the same cycle or offset by one cycle, with both aimed at the same register. The final register value and the cycle count each host waits then show which access went first and how long the parallel host was held off.

// File: rtl/ctrl_rf_pkg.sv
package ctrl_rf_pkg;
    localparam int DATA_W   = 32;
    localparam int LANES    = DATA_W / 8;
    localparam int IDX_MODE = 0;
    localparam int IDX_SYNC = 2;

    typedef enum logic [1:0] {ST_IDLE, ST_PH1, ST_PH2} arb_st_t;

    function automatic logic [DATA_W-1:0] reg_mask(input int idx);
        case (idx)
            0:       return 32'h0000_000F;
            1:       return 32'h0000_0007;
            2, 3:    return 32'hFFFF_FFFF;
            4:       return 32'h0000_FFFF;
            5:       return 32'h0000_00F7;
            7:       return 32'h0000_001F;
            9:       return 32'h0000_0007;
            6, 8, 10, 11, 12: return 32'h0000_00FF;
            default: return 32'h0000_0000;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] reg_reset(input int idx);
        return (idx == IDX_MODE) ? 32'h0000_0001 : 32'h0000_0000;
    endfunction
endpackage

// File: rtl/ctrl_rf_arb.sv
module ctrl_rf_arb
    import ctrl_rf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pp_req,
    input  logic sp_req,
    output logic cap_en,
    output logic cap_sp,
    output logic commit,
    output logic pp_ready,
    output logic sp_done
);
    typedef struct packed {
        arb_st_t st;
        logic    own_sp;
        logic    pp_ready;
        logic    sp_done;
    } arb_t;

    arb_t q, d;

    always_comb begin
        d         = q;
        d.sp_done = 1'b0;
        cap_en    = 1'b0;
        cap_sp    = 1'b0;
        commit    = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (sp_req) begin
                    cap_en   = 1'b1;
                    cap_sp   = 1'b1;
                    d.own_sp = 1'b1;
                    d.st     = ST_PH1;
                end else if (pp_req) begin
                    cap_en   = 1'b1;
                    d.own_sp = 1'b0;
                    d.st     = ST_PH1;
                end
            end
            ST_PH1: d.st = ST_PH2;
            ST_PH2: begin
                commit    = 1'b1;
                d.st      = ST_IDLE;
                d.sp_done = q.own_sp;
            end
            default: d.st = ST_IDLE;
        endcase
        d.pp_ready = (q.st == ST_PH2 && !q.own_sp) ? 1'b1 : !pp_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st       <= ST_IDLE;
            q.own_sp   <= 1'b0;
            q.pp_ready <= 1'b1;
            q.sp_done  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign pp_ready = q.pp_ready;
    assign sp_done  = q.sp_done;
endmodule

// File: rtl/ctrl_rf_bank.sv
module ctrl_rf_bank
    import ctrl_rf_pkg::*;
#(
    parameter int              ADDR_W    = 10,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h300,
    parameter int              NREG      = 14
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cap_en,
    input  logic                   cap_sp,
    input  logic                   commit,
    input  logic                   pp_wr,
    input  logic [ADDR_W-1:0]      pp_addr,
    input  logic [1:0]             pp_byte,
    input  logic [7:0]             pp_wdata,
    input  logic                   sp_wr,
    input  logic [ADDR_W-1:0]      sp_addr,
    input  logic [DATA_W-1:0]      sp_wdata,
    input  logic                   sync_load,
    output logic [7:0]             pp_rdata,
    output logic [DATA_W-1:0]      sp_rdata,
    output logic [NREG*DATA_W-1:0] cfg_flat
);
    localparam int IDX_W = $clog2(NREG);

    typedef struct packed {
        logic [NREG-1:0][DATA_W-1:0] regs;
        logic [DATA_W-1:0]           shadow;
        logic                        sp;
        logic                        wr;
        logic                        hit;
        logic [IDX_W-1:0]            idx;
        logic [DATA_W-1:0]           wdata;
        logic [LANES-1:0]            be;
        logic [1:0]                  lane;
        logic [7:0]                  pp_rdata;
        logic [DATA_W-1:0]           sp_rdata;
    } bank_t;

    bank_t q, d;

    logic [ADDR_W-1:0] sel_addr, sel_off;
    logic [DATA_W-1:0] rd_val, old_val, merged;

    always_comb begin
        d        = q;
        sel_addr = cap_sp ? sp_addr : pp_addr;
        sel_off  = sel_addr - BASE_ADDR;
        rd_val   = '0;
        old_val  = '0;
        merged   = '0;

        if (cap_en) begin
            d.sp    = cap_sp;
            d.wr    = cap_sp ? sp_wr : pp_wr;
            d.hit   = (sel_addr >= BASE_ADDR) && (sel_off < ADDR_W'(NREG));
            d.idx   = sel_off[IDX_W-1:0];
            d.wdata = cap_sp ? sp_wdata : {LANES{pp_wdata}};
            d.be    = cap_sp ? '1 : LANES'(1) << pp_byte;
            d.lane  = cap_sp ? 2'd0 : pp_byte;
        end

        if (commit) begin
            for (int i = 0; i < NREG; i++) begin
                if (q.hit && q.idx == IDX_W'(i)) begin
                    rd_val  = q.regs[i];
                    old_val = (i == IDX_SYNC) ? q.shadow : q.regs[i];
                    for (int b = 0; b < LANES; b++)
                        merged[b*8 +: 8] = q.be[b] ? q.wdata[b*8 +: 8] : old_val[b*8 +: 8];
                    if (q.wr) begin
                        if (i == IDX_SYNC) d.shadow  = merged & reg_mask(i);
                        else               d.regs[i] = merged & reg_mask(i);
                    end
                end
            end
            if (q.sp) d.sp_rdata = rd_val;
            else      d.pp_rdata = rd_val[q.lane*8 +: 8];
        end

        if (sync_load) d.regs[IDX_SYNC] = q.shadow;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) q.regs[i] <= reg_reset(i);
            q.shadow   <= '0;
            q.sp       <= 1'b0;
            q.wr       <= 1'b0;
            q.hit      <= 1'b0;
            q.idx      <= '0;
            q.wdata    <= '0;
            q.be       <= '0;
            q.lane     <= '0;
            q.pp_rdata <= '0;
            q.sp_rdata <= '0;
        end else begin
            q <= d;
        end
    end

    assign pp_rdata = q.pp_rdata;
    assign sp_rdata = q.sp_rdata;
    assign cfg_flat = q.regs;
endmodule

// File: rtl/ctrl_regfile_arb.sv
module ctrl_regfile_arb
    import ctrl_rf_pkg::*;
#(
    parameter int                ADDR_W    = 10,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h300,
    parameter int                NREG      = 14
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pp_req,
    input  logic                   pp_wr,
    input  logic [ADDR_W-1:0]      pp_addr,
    input  logic [1:0]             pp_byte,
    input  logic [7:0]             pp_wdata,
    output logic [7:0]             pp_rdata,
    output logic                   pp_ready,
    input  logic                   sp_req,
    input  logic                   sp_wr,
    input  logic [ADDR_W-1:0]      sp_addr,
    input  logic [DATA_W-1:0]      sp_wdata,
    output logic [DATA_W-1:0]      sp_rdata,
    output logic                   sp_done,
    input  logic                   sync_load,
    output logic                   soft_reset,
    output logic                   sync_master,
    output logic [NREG*DATA_W-1:0] cfg_flat
);
    logic cap_en, cap_sp, commit_w;

    ctrl_rf_arb u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .pp_req   (pp_req),
        .sp_req   (sp_req),
        .cap_en   (cap_en),
        .cap_sp   (cap_sp),
        .commit   (commit_w),
        .pp_ready (pp_ready),
        .sp_done  (sp_done)
    );

    ctrl_rf_bank #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR),
        .NREG      (NREG)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (cap_en),
        .cap_sp    (cap_sp),
        .commit    (commit_w),
        .pp_wr     (pp_wr),
        .pp_addr   (pp_addr),
        .pp_byte   (pp_byte),
        .pp_wdata  (pp_wdata),
        .sp_wr     (sp_wr),
        .sp_addr   (sp_addr),
        .sp_wdata  (sp_wdata),
        .sync_load (sync_load),
        .pp_rdata  (pp_rdata),
        .sp_rdata  (sp_rdata),
        .cfg_flat  (cfg_flat)
    );

    assign soft_reset  = cfg_flat[IDX_MODE*DATA_W + 0];
    assign sync_master = cfg_flat[IDX_MODE*DATA_W + 3];
endmodule

// File: rtl/ctrl_regfile_arb_chk.sv
module ctrl_regfile_arb_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        pp_req,
    input logic        pp_ready,
    input logic        sp_done,
    input logic        sync_load,
    input logic        soft_reset,
    input logic        sync_master,
    input logic        commit,
    input logic [31:0] mask_act
);
    AST_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (soft_reset && !sync_master)); // R4 R5

    AST_SOFT_RESET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_reset && !commit) |=> soft_reset); // R4

    AST_MASK_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_load |=> $stable(mask_act)); // R6

    AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        !(sp_done && $rose(pp_ready))); // R1

    AST_STALL_READY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pp_req) && sp_done) |-> !pp_ready); // R3

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        sp_done |=> !sp_done); // R9
endmodule

bind ctrl_regfile_arb ctrl_regfile_arb_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pp_req      (pp_req),
    .pp_ready    (pp_ready),
    .sp_done     (sp_done),
    .sync_load   (sync_load),
    .soft_reset  (soft_reset),
    .sync_master (sync_master),
    .commit      (commit_w),
    .mask_act    (cfg_flat[95:64])
);

// File: tb/ctrl_regfile_arb_test.sv
module ctrl_regfile_arb_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        pp_req = 0, pp_wr = 0;
    logic [9:0]  pp_addr = 0;
    logic [1:0]  pp_byte = 0;
    logic [7:0]  pp_wdata = 0;
    logic [7:0]  pp_rdata;
    logic        pp_ready;
    logic        sp_req = 0, sp_wr = 0;
    logic [9:0]  sp_addr = 0;
    logic [31:0] sp_wdata = 0;
    logic [31:0] sp_rdata;
    logic        sp_done;
    logic        sync_load = 0;
    logic        soft_reset, sync_master;
    logic [447:0] cfg_flat;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    ctrl_regfile_arb uut (
        .clk(clk), .rst_n(rst_n),
        .pp_req(pp_req), .pp_wr(pp_wr), .pp_addr(pp_addr), .pp_byte(pp_byte),
        .pp_wdata(pp_wdata), .pp_rdata(pp_rdata), .pp_ready(pp_ready),
        .sp_req(sp_req), .sp_wr(sp_wr), .sp_addr(sp_addr), .sp_wdata(sp_wdata),
        .sp_rdata(sp_rdata), .sp_done(sp_done), .sync_load(sync_load),
        .soft_reset(soft_reset), .sync_master(sync_master), .cfg_flat(cfg_flat)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Callers start these at a falling edge.
    task automatic pp_acc(input logic wr, input logic [9:0] a, input logic [1:0] b,
                          input logic [7:0] wd, output logic [7:0] rd, output int n);
        pp_req = 1; pp_wr = wr; pp_addr = a; pp_byte = b; pp_wdata = wd; n = 0;
        do begin @(negedge clk); n++; end while (!pp_ready && n < 40);
        rd = pp_rdata; pp_req = 0;
    endtask

    task automatic sp_acc(input logic wr, input logic [9:0] a, input logic [31:0] wd,
                          output logic [31:0] rd, output int n);
        sp_req = 1; sp_wr = wr; sp_addr = a; sp_wdata = wd; n = 0;
        do begin @(negedge clk); n++; end while (!sp_done && n < 40);
        rd = sp_rdata; sp_req = 0;
    endtask

    task automatic sp_read(input logic [9:0] a, output logic [31:0] rd);
        int n;
        sp_acc(1'b0, a, 32'h0, rd, n);
    endtask

    task automatic sp_write(input logic [9:0] a, input logic [31:0] wd);
        logic [31:0] rd; int n;
        sp_acc(1'b1, a, wd, rd, n);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        @(negedge clk);
        chk(pp_ready == 1'b1, "R9 ready high at reset", 32'(pp_ready), 32'h1);
        chk(sp_done == 1'b0, "R9 done low at reset", 32'(sp_done), 32'h0);
        chk(soft_reset == 1'b1, "R4 soft reset after reset", 32'(soft_reset), 32'h1);
        chk(sync_master == 1'b0, "R5 sync master after reset", 32'(sync_master), 32'h0);
        sp_read(10'h300, v);
        chk(v == 32'h1, "R4 R5 mode readback", v, 32'h1);
        sp_read(10'h303, v);
        chk(v == 32'h0, "R5 other register reset", v, 32'h0);
    endtask

    task automatic t_cross;
        logic [31:0] v; logic [7:0] b; int n;
        @(negedge clk);
        sp_write(10'h303, 32'h1234_5678);
        pp_acc(1'b0, 10'h303, 2'd2, 8'h0, b, n);
        chk(b == 8'h34, "R1 parallel reads serial write", 32'(b), 32'h34);
        pp_acc(1'b1, 10'h303, 2'd0, 8'hAA, b, n);
        sp_read(10'h303, v);
        chk(v == 32'h1234_56AA, "R10 byte lane merge", v, 32'h1234_56AA);
        sp_write(10'h304, 32'hABCD_1234);
        pp_acc(1'b0, 10'h304, 2'd1, 8'h0, b, n);
        chk(b == 8'h12, "R1 parallel read lane 1", 32'(b), 32'h12);
    endtask

    task automatic t_timing;
        logic [31:0] v; logic [7:0] b; int n;
        @(negedge clk);
        pp_acc(1'b0, 10'h300, 2'd0, 8'h0, b, n);
        chk(n == 3, "R9 parallel access latency", 32'(n), 32'd3);
        sp_acc(1'b0, 10'h300, 32'h0, v, n);
        chk(n == 3, "R9 serial access latency", 32'(n), 32'd3);
        @(negedge clk);
        chk(sp_done == 1'b0, "R9 done is a single pulse", 32'(sp_done), 32'h0);
    endtask

    task automatic t_reserved;
        logic [31:0] v;
        @(negedge clk);
        sp_write(10'h305, 32'hFFFF_FFFF);
        sp_read(10'h305, v);
        chk(v == 32'hF7, "R7 scale reserved bit", v, 32'hF7);
        sp_write(10'h307, 32'hFFFF_FFFF);
        sp_read(10'h307, v);
        chk(v == 32'h1F, "R7 five-bit field", v, 32'h1F);
        sp_write(10'h30D, 32'hFFFF_FFFF);
        sp_read(10'h30D, v);
        chk(v == 32'h0, "R7 reserved address", v, 32'h0);
        sp_write(10'h100, 32'h5555_5555);
        sp_read(10'h100, v);
        chk(v == 32'h0, "R8 below range reads zero", v, 32'h0);
        sp_read(10'h30E, v);
        chk(v == 32'h0, "R8 above range reads zero", v, 32'h0);
        sp_read(10'h306, v);
        chk(v == 32'h0, "R8 out-of-range write left registers", v, 32'h0);
    endtask

    task automatic t_mask;
        logic [31:0] v;
        @(negedge clk);
        sp_write(10'h302, 32'hDEAD_BEEF);
        sp_read(10'h302, v);
        chk(v == 32'h0, "R6 write goes to shadow only", v, 32'h0);
        sync_load = 1;
        @(negedge clk);
        sync_load = 0;
        sp_read(10'h302, v);
        chk(v == 32'hDEAD_BEEF, "R6 load copies shadow", v, 32'hDEAD_BEEF);
    endtask

    task automatic t_soft;
        logic [7:0] b; int n;
        @(negedge clk);
        pp_acc(1'b1, 10'h300, 2'd0, 8'h08, b, n);
        chk(soft_reset == 1'b0, "R4 soft reset cleared by write", 32'(soft_reset), 32'h0);
        chk(sync_master == 1'b1, "R5 sync master set by write", 32'(sync_master), 32'h1);
    endtask

    task automatic t_simul;
        logic [31:0] v; logic [7:0] b; int np, ns; logic rdy_at_done;
        @(negedge clk);
        fork
            pp_acc(1'b1, 10'h306, 2'd0, 8'h22, b, np);
            begin
                sp_acc(1'b1, 10'h306, 32'h11, v, ns);
                rdy_at_done = pp_ready;
            end
        join
        chk(ns == 3, "R2 serial wins tie", 32'(ns), 32'd3);
        chk(np == 6, "R3 parallel stalled then served", 32'(np), 32'd6);
        chk(rdy_at_done == 1'b0, "R3 ready low while stalled", 32'(rdy_at_done), 32'h0);
        sp_read(10'h306, v);
        chk(v == 32'h22, "R2 parallel write landed last", v, 32'h22);
    endtask

    task automatic t_inflight;
        logic [31:0] v; logic [7:0] b; int np, ns;
        @(negedge clk);
        fork
            pp_acc(1'b1, 10'h308, 2'd0, 8'h33, b, np);
            begin
                @(negedge clk);
                sp_acc(1'b1, 10'h308, 32'h44, v, ns);
            end
        join
        chk(np == 3, "R2 in-flight parallel finishes", 32'(np), 32'd3);
        chk(ns == 5, "R2 serial waits for parallel", 32'(ns), 32'd5);
        sp_read(10'h308, v);
        chk(v == 32'h44, "R2 serial write landed last", v, 32'h44);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_cross();
        t_timing();
        t_reserved();
        t_mask();
        t_soft();
        t_simul();
        t_inflight();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule